// File: doc/BRIEF.md
# Field-Synchronous Video Source Selector

This block drives the select line of an external two-way analog video switch. It decides, from the timing of the incoming video, whether a camera A or a camera B picture reaches the output. Its inputs come from a sync separator: an active-high composite sync, an active-high colour-burst gate and an odd/even field flag. It also takes a two-bit mode setting from jumpers. All of these are asynchronous to the local oscillator clock. The block brings them into the clock domain and finds vertical intervals and scan-line starts from them. It counts lines within a field, oscillator clocks within a line, and even fields.

The select can be driven four ways. It can follow the field flag, so that interleaved fields come from different cameras. It can pick A for a band of lines only. It can swap cameras every N even fields. It can show A on the left part of each line and B from a chosen column onward. A new mode setting waits for the next vertical interval. The select register moves only at a line start or at the column match, so the analog switch never flips in the middle of a picture element.

Top module: `video_source_selector`

## Requirements
- R1: After reset `selA` is 0 (camera B), and the block behaves as per-field mode until the first vertical interval is detected, whatever `modeIn` holds.
- R2: At each falling edge of the synchronized burst gate, the synchronized sync level is sampled: 1 means the block is inside the vertical interval, 0 means it has left it.
- R3: A rising sync edge seen while the block is outside the vertical interval sets a line-start marker. Each marker counts exactly one line. The marker clears at the next burst-gate falling edge, and sync pulses inside the vertical interval set no marker.
- R4: The line count is `LINE_W` bits wide. It is forced to 0 while the vertical indication is set and increments by one at each line-start marker, wrapping modulo 2^LINE_W.
- R5: Mode 2'b00 (per field): at each line-start marker `selA` takes the synchronized field flag, where 1 (odd field) selects A.
- R6: Mode 2'b01 (line band): at each line-start marker `selA` becomes 1 if the new line count is from `BAND_FIRST` to `BAND_LAST` inclusive (defaults 128 and 191, i.e. strictly above 127 and below 192), and 0 otherwise.
- R7: Mode 2'b10 (every N frames): a counter counts falling edges of the field flag, which mark even-field starts. On every `FRAME_N`-th one an internal camera choice toggles, starting from B after reset. At each line-start marker `selA` takes that choice.
- R8: Mode 2'b11 (column split): the column counter restarts at 0 on each line-start marker, where `selA` becomes 1. The counter then advances once per clock, saturating at its maximum. When it equals `COL_SPLIT`, `selA` becomes 0.
- R9: The mode setting `modeIn` is taken into the active mode only when the vertical indication rises. A change of `modeIn` in the middle of a field has no effect on the select until that point.
- R10: `selA` changes only in the cycle after a line-start marker or a column match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncIn | input | 1 | Composite sync, active high, asynchronous |
| burstIn | input | 1 | Colour-burst gate, active high, asynchronous |
| fieldIn | input | 1 | Field flag, 1 = odd field, asynchronous |
| modeIn | input | 2 | Mode jumpers: 00 field, 01 band, 10 every N frames, 11 column split |
| selA | output | 1 | Registered switch select, 1 = input A, 0 = input B |

## Verification
Several properties are checked on every cycle. The vertical indication changes only at a burst-gate falling edge, and the line-start marker clears there. The line count is zero after any vertical cycle. The active mode is frozen outside vertical-interval starts. The select never moves without a marker or a column match. In per-field mode the select follows the field flag, and in band mode every rise of the select falls inside the band. The bench scenarios show what needs whole fields of video. These cover the exact line numbers at which the band opens and closes, and the skipped line right after a vertical interval. They also cover the toggle period in every-N-frames mode, the left and right halves of a line in column mode, and the delay of a mid-field mode change until the next vertical interval.

// File: rtl/vss_pkg.sv
package vss_pkg;

  typedef enum logic [1:0] {
    MODE_FIELD  = 2'b00,
    MODE_BAND   = 2'b01,
    MODE_FRAMES = 2'b10,
    MODE_COLUMN = 2'b11
  } selMode_e;

  // strobes passed from timing recovery to the selection datapath
  typedef struct packed {
    logic lineTick;   // one-cycle line-start marker event
    logic vertStart;  // one-cycle rise of the vertical indication
    logic inVert;     // vertical indication level
    logic evenStart;  // one-cycle falling edge of the field flag
  } timingStrobes_t;

endpackage

// File: rtl/vss_sync.sv
module vss_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/vss_timing.sv
module vss_timing
  import vss_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           syncS,
  input  logic           burstS,
  input  logic           fieldS,
  output timingStrobes_t strobes
);

  logic syncD, burstD, fieldD;
  logic vert, hMark;
  logic burstFall, syncRise, markSet;

  assign burstFall = burstD & ~burstS;
  assign syncRise  = syncS & ~syncD;
  assign markSet   = syncRise & ~vert & ~hMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncD  <= 1'b0;
      burstD <= 1'b0;
      fieldD <= 1'b0;
    end else begin
      syncD  <= syncS;
      burstD <= burstS;
      fieldD <= fieldS;
    end
  end

  // vertical indication: sync level sampled at burst-gate fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vert <= 1'b0;
    end else if (burstFall) begin
      vert <= syncS;
    end
  end

  // line-start marker: set by sync outside vertical, cleared by burst fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hMark <= 1'b0;
    end else if (markSet) begin
      hMark <= 1'b1;
    end else if (burstFall) begin
      hMark <= 1'b0;
    end
  end

  always_comb begin
    strobes.lineTick  = markSet;
    strobes.vertStart = burstFall & syncS & ~vert;
    strobes.inVert    = vert;
    strobes.evenStart = fieldD & ~fieldS;
  end

  AST_VERT_ONLY_AT_BURST_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !burstFall |=> $stable(vert)); // R2

  AST_MARK_CLEARS_AT_BURST_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (burstFall && !syncRise) |=> !hMark); // R3

endmodule

// File: rtl/vss_datapath.sv
module vss_datapath
  import vss_pkg::*;
#(
  parameter int LINE_W     = 8,
  parameter int BAND_FIRST = 128,
  parameter int BAND_LAST  = 191,
  parameter int FRAME_N    = 4,
  parameter int COL_W      = 11,
  parameter int COL_SPLIT  = 858
) (
  input  logic           clk,
  input  logic           rstN,
  input  timingStrobes_t strobes,
  input  logic           fieldS,
  input  logic [1:0]     modeS,
  output logic           selA
);

  localparam int EVEN_W = (FRAME_N > 1) ? $clog2(FRAME_N) : 1;
  localparam logic [EVEN_W-1:0] EVEN_LAST = EVEN_W'(FRAME_N - 1);
  localparam logic [LINE_W-1:0] BAND_LO   = LINE_W'(BAND_FIRST);
  localparam logic [LINE_W-1:0] BAND_HI   = LINE_W'(BAND_LAST);
  localparam logic [COL_W-1:0]  COL_MATCH = COL_W'(COL_SPLIT);
  localparam logic [COL_W-1:0]  COL_MAX   = '1;

  selMode_e          activeMode;
  logic [LINE_W-1:0] lineCnt, lineNext;
  logic [COL_W-1:0]  colCnt;
  logic [EVEN_W-1:0] evenCnt;
  logic              frameSel;
  logic              inBand, colMatch, tickSel;

  // active mode, refreshed only at the start of a vertical interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode <= MODE_FIELD;
    end else if (strobes.vertStart) begin
      activeMode <= selMode_e'(modeS);
    end
  end

  // line counter
  assign lineNext = lineCnt + 1'b1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (strobes.inVert) begin
      lineCnt <= '0;
    end else if (strobes.lineTick) begin
      lineCnt <= lineNext;
    end
  end

  // column counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
    end else if (strobes.lineTick) begin
      colCnt <= '0;
    end else if (colCnt != COL_MAX) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  // even-field counter and frame choice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evenCnt  <= '0;
      frameSel <= 1'b0;
    end else if (strobes.evenStart) begin
      if (evenCnt == EVEN_LAST) begin
        evenCnt  <= '0;
        frameSel <= ~frameSel;
      end else begin
        evenCnt <= evenCnt + 1'b1;
      end
    end
  end

  assign inBand   = (lineNext >= BAND_LO) && (lineNext <= BAND_HI);
  assign colMatch = (activeMode == MODE_COLUMN) && (colCnt == COL_MATCH);

  always_comb begin
    unique case (activeMode)
      MODE_FIELD:  tickSel = fieldS;
      MODE_BAND:   tickSel = inBand;
      MODE_FRAMES: tickSel = frameSel;
      default:     tickSel = 1'b1;
    endcase
  end

  // registered select, moves only at a line start or column match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selA <= 1'b0;
    end else if (strobes.lineTick) begin
      selA <= tickSel;
    end else if (colMatch) begin
      selA <= 1'b0;
    end
  end

  AST_LINE_ZERO_IN_VERT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inVert |=> (lineCnt == '0)); // R4

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.vertStart |=> $stable(activeMode)); // R9

  AST_SEL_AT_EVENTS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.lineTick || colMatch) |=> $stable(selA)); // R10

  AST_FIELD_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == MODE_FIELD && strobes.lineTick) |=> (selA == $past(fieldS))); // R5

  AST_BAND_RISE_IN_BAND: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == MODE_BAND && $rose(selA)) |-> (lineCnt >= BAND_LO && lineCnt <= BAND_HI)); // R6

endmodule

// File: rtl/video_source_selector.sv
module video_source_selector
  import vss_pkg::*;
#(
  parameter int LINE_W     = 8,
  parameter int BAND_FIRST = 128,
  parameter int BAND_LAST  = 191,
  parameter int FRAME_N    = 4,
  parameter int COL_W      = 11,
  parameter int COL_SPLIT  = 858,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       burstIn,
  input  logic       fieldIn,
  input  logic [1:0] modeIn,
  output logic       selA
);

  localparam int IN_W = 5;

  logic [IN_W-1:0] rawIn, syncedIn;
  timingStrobes_t  strobes;

  assign rawIn = {modeIn, fieldIn, burstIn, syncIn};

  vss_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncedIn)
  );

  vss_timing timing_i (
    .clk     (clk),
    .rstN    (rstN),
    .syncS   (syncedIn[0]),
    .burstS  (syncedIn[1]),
    .fieldS  (syncedIn[2]),
    .strobes (strobes)
  );

  vss_datapath #(
    .LINE_W     (LINE_W),
    .BAND_FIRST (BAND_FIRST),
    .BAND_LAST  (BAND_LAST),
    .FRAME_N    (FRAME_N),
    .COL_W      (COL_W),
    .COL_SPLIT  (COL_SPLIT)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .fieldS  (syncedIn[2]),
    .modeS   (syncedIn[4:3]),
    .selA    (selA)
  );

endmodule

// File: tb/video_source_selector_tb_top.sv
`timescale 1ns/1ps
module video_source_selector_tb_top;

  localparam int NFR  = 2;
  localparam int COLS = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic       burstIn = 1'b0;
  logic       fieldIn = 1'b1;
  logic [1:0] modeIn = 2'b01;
  logic       selA;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    bit    exp;
  } item_t;
  item_t sbq[$];

  // reference model state
  bit       mVert = 1'b0;
  bit       mSel = 1'b0;
  bit       mFrameSel = 1'b0;
  bit       mPrevField = 1'b1;
  logic [7:0] mLine = '0;
  logic [1:0] mMode = 2'b00;
  int       mEven = 0;

  always #10 clk = ~clk;

  video_source_selector #(.FRAME_N(NFR), .COL_SPLIT(COLS)) dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .burstIn(burstIn),
    .fieldIn(fieldIn), .modeIn(modeIn), .selA(selA)
  );

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00:   return "R5";
      2'b01:   return "R6 R4 R3 R2";
      2'b10:   return "R7";
      default: return "R8 R10";
    endcase
  endfunction

  task automatic pushExp(input string tag, input bit e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLine(input bit isVert, input string extra);
    bit ticked;
    ticked = !mVert;
    if (ticked) begin
      mLine = mLine + 8'd1;
      case (mMode)
        2'b00:   mSel = fieldIn;
        2'b01:   mSel = (mLine >= 8'd128) && (mLine <= 8'd191);
        2'b10:   mSel = mFrameSel;
        default: mSel = 1'b1;
      endcase
    end
    syncIn = 1'b1;
    if (isVert) begin
      waitN(10);
      burstIn = 1'b1;
      waitN(4);
      burstIn = 1'b0;
      if (!mVert) mMode = modeIn;
      mVert = 1'b1;
      mLine = '0;
      if (mMode == 2'b11 && ticked) mSel = 1'b0;
      waitN(16);
      syncIn = 1'b0;
      waitN(20);
    end else begin
      waitN(4);
      syncIn = 1'b0;
      waitN(2);
      burstIn = 1'b1;
      waitN(4);
      burstIn = 1'b0;
      mVert = 1'b0;
      waitN(2);
      pushExp({modeTag(mMode), extra}, mSel);
      if (mMode == 2'b11 && ticked) mSel = 1'b0;
      waitN(28);
      pushExp({modeTag(mMode), extra}, mSel);
      waitN(10);
    end
  endtask

  task automatic runField(input bit fld, input int n, input int chgAt, input logic [1:0] newMode);
    if (mPrevField && !fld) begin
      mEven++;
      if (mEven == NFR) begin
        mEven = 0;
        mFrameSel = ~mFrameSel;
      end
    end
    mPrevField = fld;
    fieldIn = fld;
    waitN(4);
    for (int v = 0; v < 3; v++) doLine(1'b1, "");
    for (int i = 0; i < n; i++) begin
      if (i == chgAt) modeIn = newMode;
      doLine(1'b0, (chgAt >= 0 && i >= chgAt) ? " R9" : "");
    end
  endtask

  // monitor: pops expected items and compares with the output
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks++;
        if (selA !== it.exp) begin
          errors++;
          $display("FAIL %s: selA=%0b expected %0b at %0t", it.tag, selA, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    checks++;
    if (selA !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset selA=%0b expected 0", selA);
    end
    // before any vertical interval: per-field behaviour despite modeIn=01
    for (int i = 0; i < 5; i++) doLine(1'b0, " R1 R9");
    runField(1'b0, 200, -1, 2'b01);
    runField(1'b1, 200, 150, 2'b00);
    runField(1'b0, 20, -1, 2'b00);
    runField(1'b1, 20, 10, 2'b10);
    for (int f = 0; f < 8; f++) runField(f[0] ? 1'b1 : 1'b0, 20, (f == 7) ? 10 : -1, 2'b11);
    runField(1'b0, 20, -1, 2'b11);
    runField(1'b1, 20, 10, 2'b00);
    runField(1'b0, 20, -1, 2'b00);
    while (sbq.size() > 0) waitN(1);
    waitN(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule